// File: doc/BRIEF.md
# Pointer-Compare Sync Event Interrupt Controller

This block raises host interrupts for a transport-stream preparser and the channel buffer behind it. An 8-bit status register collects events. A mask register of the same width decides which of those events reach the active-low interrupt line. The host reads and writes both registers, plus a mode register and two 24-bit compare values, through a simple register port. Reading the status register returns its contents and clears them in the same cycle.

Three status bits follow preparser strobes directly: audio packet found, video packet found, and video sequence end found. The two timestamp bits work in two stages and are used for audio/video synchronization. A channel is armed when the buffer read pointer becomes equal to that channel's compare value while the channel is enabled. The timestamp bit is set only by the first matching start code that arrives after arming: the audio sync code for the audio channel, the picture start code for the video channel.

Register map (4-bit address): 0 status (read clears it, writes are ignored), 1 mask, 2 mode, 3/4/5 audio compare bytes low/mid/high, 6/7/8 video compare bytes low/mid/high.

Top module: `sync_irq_ctrl`

## Requirements
- R1: The status bits are laid out as follows. Bit 0 is set by `aud_pes_i`, bit 1 by `vid_pes_i` and bit 3 by `seq_end_i`, each one cycle after the strobe. Bit 6 is the audio timestamp and bit 7 is the video timestamp. Bits 2, 4 and 5 always read 0.
- R2: A status read (`reg_rd_i` at address 0) returns the current bits and clears all of them at the same clock edge. A write to address 0 changes nothing.
- R3: An event that sets a bit in the same cycle as a clearing status read is kept, so the next read returns that bit as 1.
- R4: `irq_no` is registered from the status and the mask. It is low one cycle after any status bit is 1 while its mask bit is 0. It is high when every set bit is masked or no bit is set. The mask resets to 0.
- R5: The host can write each compare byte and read it back; the low byte holds pointer bits 7:0. The mode register keeps only bits 2:0 and reads 0 in bits 7:3. Bit 0 enables video compare. Bits 2:1 form the audio field, and any nonzero value enables audio compare.
- R6: A compare pulse occurs only in the first cycle in which the enabled channel's 24-bit value equals `rd_ptr_i`. A pointer that differs in any one bit does not arm the channel. A pointer that stays equal does not arm it again.
- R7: The audio timestamp bit (bit 6) is set one cycle after the first `aud_sync_i` that arrives in a cycle after the audio pulse. A sync in the same cycle as the pulse, or a sync with no pulse, does not set it.
- R8: The video timestamp bit (bit 7) is set one cycle after the first `pic_start_i` that arrives after the video pulse. A picture start with no pulse does not set it.
- R9: A second pulse while a channel is already armed is ignored, so one start code sets the bit once and a later code does nothing.
- R10: Clearing a channel's enable returns it from armed to idle, and a start code after that does not set its bit.
- R11: While a channel's enable is off, pointer equality never arms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears status at address 0) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current address, combinational |
| aud_pes_i | input | 1 | Audio packet detected strobe |
| vid_pes_i | input | 1 | Video packet detected strobe |
| seq_end_i | input | 1 | Video sequence end detected strobe |
| aud_sync_i | input | 1 | Audio sync code strobe |
| pic_start_i | input | 1 | Picture start code strobe |
| rd_ptr_i | input | 24 | Channel buffer read pointer |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions assume three things about the inputs. Detection strobes are single-cycle. The read pointer holds its value for at least one cycle between changes, so each equality episode is a separate run of cycles. The host never reads and writes in the same cycle. The bench drives every strobe for exactly one cycle and changes the pointer only at falling edges with a full cycle between steps. It issues register reads and writes one at a time. Each pointer sweep moves the pointer away from the compare value before the next episode starts.

// File: rtl/sync_irq_pkg.sv
package sync_irq_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned ADDR_STATUS   = 0;
  localparam int unsigned ADDR_MASK     = 1;
  localparam int unsigned ADDR_MODE     = 2;
  localparam int unsigned ADDR_CMP_BASE = 3;

  localparam int unsigned BIT_APES = 0;
  localparam int unsigned BIT_VPES = 1;
  localparam int unsigned BIT_SEQE = 3;
  localparam int unsigned BIT_ATS  = 6;
  localparam int unsigned BIT_VTS  = 7;

  localparam int unsigned MODE_W = 3;

  // channel index: 0 audio, 1 video
  localparam int unsigned NUM_CH = 2;
  localparam int unsigned CH_AUD = 0;
  localparam int unsigned CH_VID = 1;

  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_WAIT = 1'b1
  } arm_state_e;
endpackage

// File: rtl/sync_irq_regs.sv
module sync_irq_regs
  import sync_irq_pkg::*;
#(
  parameter int unsigned PTR_W  = 24,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  output logic [REG_W-1:0]              mask_o,
  output logic [NUM_CH-1:0]             en_o,
  output logic [NUM_CH-1:0][PTR_W-1:0]  cmp_o
);
  localparam int unsigned NB     = (PTR_W + REG_W - 1) / REG_W;
  localparam int unsigned FLAT_W = NB * REG_W;

  logic [REG_W-1:0]                       mask_q;
  logic [MODE_W-1:0]                      mode_q;
  logic [NUM_CH-1:0][NB-1:0][REG_W-1:0]   cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      mode_q <= '0;
      cmp_q  <= '0;
    end else if (wr_i) begin
      if (addr_i == ADDR_W'(ADDR_MASK)) mask_q <= wdata_i;
      if (addr_i == ADDR_W'(ADDR_MODE)) mode_q <= wdata_i[MODE_W-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        for (int b = 0; b < NB; b++) begin
          if (addr_i == ADDR_W'(ADDR_CMP_BASE + c*NB + b)) cmp_q[c][b] <= wdata_i;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(ADDR_MASK)) rdata_o = mask_q;
    if (addr_i == ADDR_W'(ADDR_MODE)) rdata_o = REG_W'(mode_q);
    for (int c = 0; c < NUM_CH; c++) begin
      for (int b = 0; b < NB; b++) begin
        if (addr_i == ADDR_W'(ADDR_CMP_BASE + c*NB + b)) rdata_o = cmp_q[c][b];
      end
    end
  end

  assign mask_o       = mask_q;
  assign en_o[CH_VID] = mode_q[0];
  assign en_o[CH_AUD] = |mode_q[2:1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_cmp
    logic [FLAT_W-1:0] flat;
    assign flat     = cmp_q[c];
    assign cmp_o[c] = flat[PTR_W-1:0];
  end

  assert_mode_rsvd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == ADDR_W'(ADDR_MODE)) |=> (en_o[CH_VID] == $past(wdata_i[0])));
endmodule

// File: rtl/sync_irq_arm.sv
module sync_irq_arm
  import sync_irq_pkg::*;
#(
  parameter int unsigned PTR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [PTR_W-1:0] cmp_i,
  input  logic             code_i,
  output logic             fire_o
);
  logic       match, match_q, pulse;
  arm_state_e state_q, state_d;

  assign match = en_i && (ptr_i == cmp_i);
  assign pulse = match && !match_q;

  always_comb begin
    state_d = state_q;
    fire_o  = 1'b0;
    unique case (state_q)
      ARM_IDLE: if (pulse) state_d = ARM_WAIT;
      ARM_WAIT: begin
        if (!en_i) state_d = ARM_IDLE;
        else if (code_i) begin
          fire_o  = 1'b1;
          state_d = ARM_IDLE;
        end
      end
      default: state_d = ARM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      state_q <= ARM_IDLE;
    end else begin
      match_q <= match;
      state_q <= state_d;
    end
  end

  assert_pulse_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse |=> !pulse);
  assert_no_arm_disabled_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && state_q == ARM_IDLE) |=> state_q == ARM_IDLE);
  assert_disable_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> state_q == ARM_IDLE);
  assert_rearm_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARM_WAIT && pulse && !code_i) |=> state_q == ARM_WAIT);
  assert_fire_from_wait_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ARM_IDLE) |-> !fire_o);
endmodule

// File: rtl/sync_irq_status.sv
module sync_irq_status
  import sync_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [REG_W-1:0] set_i,
  input  logic             rd_clr_i,
  input  logic [REG_W-1:0] mask_i,
  output logic [REG_W-1:0] status_o,
  output logic             irq_no
);
  logic [REG_W-1:0] status_q;
  logic             irq_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      irq_nq   <= 1'b1;
    end else begin
      status_q <= (rd_clr_i ? '0 : status_q) | set_i;
      irq_nq   <= ~|(status_q & ~mask_i);
    end
  end

  assign status_o = status_q;
  assign irq_no   = irq_nq;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    assert_set_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[b] |=> status_o[b]);
  end

  assert_rd_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && set_i == '0) |=> status_o == '0);
  assert_irq_active_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_o & ~mask_i)) |=> !irq_no);
  assert_irq_quiet_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o & ~mask_i) == '0) |=> irq_no);
endmodule

// File: rtl/sync_irq_ctrl.sv
module sync_irq_ctrl
  import sync_irq_pkg::*;
#(
  parameter int unsigned PTR_W  = 24,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              aud_pes_i,
  input  logic              vid_pes_i,
  input  logic              seq_end_i,
  input  logic              aud_sync_i,
  input  logic              pic_start_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic              irq_no
);
  logic [REG_W-1:0]              mask, status, regs_rdata, set_vec;
  logic [NUM_CH-1:0]             ch_en, ch_code, ch_fire;
  logic [NUM_CH-1:0][PTR_W-1:0]  ch_cmp;
  logic                          sel_status, rd_clr;

  assign sel_status = (reg_addr_i == ADDR_W'(ADDR_STATUS));
  assign rd_clr     = reg_rd_i && sel_status;

  sync_irq_regs #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .rdata_o (regs_rdata),
    .mask_o  (mask),
    .en_o    (ch_en),
    .cmp_o   (ch_cmp)
  );

  assign ch_code[CH_AUD] = aud_sync_i;
  assign ch_code[CH_VID] = pic_start_i;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    sync_irq_arm #(.PTR_W(PTR_W)) arm_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en[c]),
      .ptr_i  (rd_ptr_i),
      .cmp_i  (ch_cmp[c]),
      .code_i (ch_code[c]),
      .fire_o (ch_fire[c])
    );
  end

  always_comb begin
    set_vec           = '0;
    set_vec[BIT_APES] = aud_pes_i;
    set_vec[BIT_VPES] = vid_pes_i;
    set_vec[BIT_SEQE] = seq_end_i;
    set_vec[BIT_ATS]  = ch_fire[CH_AUD];
    set_vec[BIT_VTS]  = ch_fire[CH_VID];
  end

  sync_irq_status status_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_vec),
    .rd_clr_i (rd_clr),
    .mask_i   (mask),
    .status_o (status),
    .irq_no   (irq_no)
  );

  assign reg_rdata_o = sel_status ? status : regs_rdata;

  assert_rsvd_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_status && reg_rd_i) |-> (reg_rdata_o[2] == 1'b0 && reg_rdata_o[5:4] == 2'b00));
  assert_status_wr_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && sel_status && !reg_rd_i && set_vec == '0) |=> $stable(status));
endmodule

// File: tb/sync_irq_ctrl_tb_top.sv
module sync_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [7:0]  wdata = '0, rdata;
  logic        aud_pes = 0, vid_pes = 0, seq_end = 0, aud_sync = 0, pic_start = 0;
  logic [23:0] ptr = 24'h000001;
  logic        irq_n;

  int checks = 0;
  int errors = 0;

  localparam logic [23:0] ACMP = 24'h123456;
  localparam logic [23:0] VCMP = 24'hABCDEF;

  always #5 clk = ~clk;

  sync_irq_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .aud_pes_i(aud_pes), .vid_pes_i(vid_pes),
    .seq_end_i(seq_end), .aud_sync_i(aud_sync), .pic_start_i(pic_start),
    .rd_ptr_i(ptr), .irq_no(irq_n)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] v);
    addr = a; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  // sel: 0 aud_pes, 1 vid_pes, 2 seq_end, 3 aud_sync, 4 pic_start
  task automatic strobe(input logic [4:0] sel);
    {pic_start, aud_sync, seq_end, vid_pes, aud_pes} = sel;
    @(negedge clk);
    {pic_start, aud_sync, seq_end, vid_pes, aud_pes} = '0;
  endtask

  task automatic set_ptr(input logic [23:0] v);
    ptr = v;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // reset state
    chk("R4 reset irq", irq_n, 1);
    rd_reg(0, v); chk("R2 reset status", v, 0);
    rd_reg(1, v); chk("R4 reset mask", v, 0);
    rd_reg(2, v); chk("R5 reset mode", v, 0);

    // R5 compare bytes and mode readback
    for (int b = 0; b < 3; b++) begin
      wr_reg(4'(3 + b), ACMP[b*8 +: 8]);
      wr_reg(4'(6 + b), VCMP[b*8 +: 8]);
    end
    for (int b = 0; b < 3; b++) begin
      rd_reg(4'(3 + b), v); chk("R5 audio cmp byte", v, ACMP[b*8 +: 8]);
      rd_reg(4'(6 + b), v); chk("R5 video cmp byte", v, VCMP[b*8 +: 8]);
    end
    for (int m = 0; m < 8; m++) begin
      wr_reg(2, 8'hF8 | 8'(m));
      rd_reg(2, v); chk("R5 mode readback", v, 8'(m));
    end
    wr_reg(2, 8'hF8);

    // R1 direct strobes, R2 clear and write-ignore
    for (int s = 0; s < 3; s++) begin
      logic [7:0] e;
      e = (s == 0) ? 8'h01 : (s == 1) ? 8'h02 : 8'h08;
      strobe(5'(1 << s));
      rd_reg(0, v); chk("R1 direct strobe bit", v, e);
      rd_reg(0, v); chk("R2 cleared after read", v, 0);
    end
    strobe(5'b00001);
    wr_reg(0, 8'h00);
    rd_reg(0, v); chk("R2 write to status ignored", v, 8'h01);
    wr_reg(0, 8'hFF);
    rd_reg(0, v); chk("R2 write ones ignored", v, 0);

    // R4 mask sweep, R1 reserved bits
    for (int m = 0; m < 256; m++) begin
      wr_reg(1, 8'(m));
      strobe(5'b00111);
      tick(1);
      chk("R4 irq vs mask", irq_n, ((8'h0B & ~8'(m)) == 0) ? 1 : 0);
      rd_reg(0, v); chk("R1 status pattern", v, 8'h0B);
      tick(1);
      chk("R4 irq released", irq_n, 1);
    end
    wr_reg(1, 8'h00);

    // R3 set wins over clear
    strobe(5'b00010);
    addr = 0; rd = 1'b1; vid_pes = 1'b1;
    tick(1);
    rd = 1'b0; vid_pes = 1'b0;
    rd_reg(0, v); chk("R3 set wins over read clear", v, 8'h02);

    // R7 audio pointer sweep for each nonzero audio field, R11 disabled field
    for (int f = 0; f < 4; f++) begin
      wr_reg(2, 8'(f << 1));
      for (int k = -3; k <= 3; k++) begin
        set_ptr(ACMP + 24'(k));
        strobe(5'b01000);
        rd_reg(0, v);
        chk((f == 0) ? "R11 audio disabled" : "R7 audio sweep", v,
            (f != 0 && k == 0) ? 8'h40 : 8'h00);
      end
      set_ptr(24'h000001);
    end

    // R6 single-bit differences never arm
    wr_reg(2, 8'h04);
    for (int b = 0; b < 24; b++) begin
      set_ptr(ACMP ^ (24'h1 << b));
      strobe(5'b01000);
      rd_reg(0, v); chk("R6 audio bit mismatch", v, 0);
    end
    set_ptr(24'h000001);

    // R6 held equality arms once
    set_ptr(ACMP);
    strobe(5'b01000);
    rd_reg(0, v); chk("R6 first after pulse", v, 8'h40);
    strobe(5'b01000);
    rd_reg(0, v); chk("R6 no rearm while held", v, 0);
    set_ptr(24'h000001);

    // R7 sync in pulse cycle is not counted but leaves channel armed
    ptr = ACMP; aud_sync = 1'b1;
    tick(1);
    aud_sync = 1'b0;
    rd_reg(0, v); chk("R7 same-cycle sync ignored", v, 0);
    strobe(5'b01000);
    rd_reg(0, v); chk("R7 next sync sets", v, 8'h40);
    set_ptr(24'h000001);

    // R8 video sweep, R11 video disabled
    for (int en = 0; en < 2; en++) begin
      wr_reg(2, 8'(en));
      for (int k = -3; k <= 3; k++) begin
        set_ptr(VCMP + 24'(k));
        strobe(5'b10000);
        rd_reg(0, v);
        chk((en == 0) ? "R11 video disabled" : "R8 video sweep", v,
            (en != 0 && k == 0) ? 8'h80 : 8'h00);
      end
      set_ptr(24'h000001);
    end
    wr_reg(2, 8'h01);
    strobe(5'b10000);
    rd_reg(0, v); chk("R8 start code without pulse", v, 0);

    // R9 second pulse while armed ignored
    set_ptr(VCMP);
    set_ptr(24'h000001);
    set_ptr(VCMP);
    strobe(5'b10000);
    rd_reg(0, v); chk("R9 one event", v, 8'h80);
    set_ptr(24'h000001);
    strobe(5'b10000);
    rd_reg(0, v); chk("R9 no second event", v, 0);

    // R10 disable returns to idle
    set_ptr(VCMP);
    set_ptr(24'h000001);
    wr_reg(2, 8'h00);
    strobe(5'b10000);
    rd_reg(0, v); chk("R10 disabled while armed", v, 0);
    wr_reg(2, 8'h01);
    strobe(5'b10000);
    rd_reg(0, v); chk("R10 re-enabled stays idle", v, 0);

    // R4 timestamp bit drives irq; masked timestamp does not
    set_ptr(VCMP);
    strobe(5'b10000);
    tick(1);
    chk("R4 irq from video timestamp", irq_n, 0);
    rd_reg(0, v); chk("R8 status for irq", v, 8'h80);
    tick(1);
    chk("R4 irq release after read", irq_n, 1);
    set_ptr(24'h000001);
    wr_reg(1, 8'h80);
    set_ptr(VCMP);
    strobe(5'b10000);
    tick(1);
    chk("R4 masked timestamp irq", irq_n, 1);
    rd_reg(0, v); chk("R4 masked bit still recorded", v, 8'h80);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule